// File: doc/BRIEF.md
# RTC Update Cycle Sequencer

This block paces the once-per-second advance of a real-time clock's time and date counters. When the one-second tick arrives it raises an update-in-progress flag, waits a fixed lead time measured in microsecond timebase pulses, and only then issues a one-cycle advance strobe to the external calendar counters. While the counters settle it holds off host access for a fixed busy window. At the end of the window the flag drops, an update-ended pulse is issued, and the freshly advanced seconds, minutes and hours are compared with the alarm values to produce an alarm pulse.

A host that polls the flag and finds it low therefore always has at least the full lead time before any counter moves. A host that wants to write the clock sets the inhibit input: ticks are then dropped and the flag never rises, and clearing inhibit lets the next tick start a normal update. The calendar arithmetic itself sits outside this block; the current time bytes come in as inputs.

Top module: `rtc_update_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, uip, bus_hold, advance, upd_end and alarm are all 0.
- R2: A sec_tick sampled high while idle and not inhibited makes uip 1 in the following cycle.
- R3: The advance strobe is exactly one cycle wide and appears after LEAD_US (default 244) sampled us_tick pulses of uip being high; bus_hold is 0 before that cycle and 1 from that cycle until uip falls.
- R4: uip stays high for exactly LEAD_US + BUSY_US (default 244 + 1984 = 2228) sampled us_tick pulses and then falls.
- R5: upd_end pulses for one cycle, in the first cycle with uip low, after each update that reached the advance strobe.
- R6: alarm pulses in the same cycle as upd_end when the current seconds, minutes and hours each equal their alarm byte; all 8 bits of each byte are compared, so hours bit 7 (PM flag in 12-hour mode) must match too.
- R7: If any one of the three bytes differs from its alarm byte, no alarm pulse occurs.
- R8: A sec_tick sampled while inhibit is 1 is dropped: uip stays 0 and no advance or upd_end follows; after inhibit returns to 0 the next tick starts a normal update.
- R9: Raising inhibit during the lead window aborts the update: uip falls in the next cycle and no advance or upd_end follows.
- R10: Raising inhibit after the advance strobe does not abort: uip falls and upd_end pulses at the normal time.
- R11: Timing counts only us_tick pulses: with us_tick high every other cycle, uip stays high for 2*(LEAD_US+BUSY_US) cycles, give or take one for phase.
- R12: A sec_tick arriving while an update is in progress is ignored and does not restart or lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| us_tick | input | 1 | Microsecond timebase pulse |
| inhibit | input | 1 | Hold-off for clock setting; blocks updates |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte (bit 7 PM in 12-hour mode) |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| uip | output | 1 | Update-in-progress flag |
| bus_hold | output | 1 | Host access to counters held off |
| advance | output | 1 | One-cycle counter advance strobe |
| upd_end | output | 1 | One-cycle update-ended event |
| alarm | output | 1 | One-cycle alarm event |

## Verification
The bench attacks the exact placement of the advance strobe and the fall of uip, since an off-by-one lead counter would move the counters before the promised window and shorten the host's safe access time. It sets inhibit in each phase: before the tick (a design that still latched the tick would raise uip while the host writes), inside the lead window (one that ignored it would still strobe the counters) and inside the busy window (one that aborted there would lose the update-ended event after the counters already moved). It checks alarm against a PM/AM hours mismatch and a single-field mismatch, where a design comparing only seven bits or only some fields would fire falsely, sends a second tick mid-update that a careless design would use to restart, and halves the timebase to catch timing tied to the clock instead of us_tick.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_BUSY = 2'd2
    } upd_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } clk_time_t;

    // Full-byte comparison of all three fields; hours bit 7 included.
    function automatic logic time_match(input clk_time_t now_t, input clk_time_t alm_t);
        logic eq_s, eq_m, eq_h;
        eq_s = (now_t.sec == alm_t.sec);
        eq_m = (now_t.min == alm_t.min);
        eq_h = (now_t.hr  == alm_t.hr);
        return eq_s && eq_m && eq_h;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rtc_us_timer.sv
module rtc_us_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_upd_fsm.sv
module rtc_upd_fsm
    import rtc_seq_pkg::*;
#(
    parameter int LEAD_US = 244,
    parameter int BUSY_US = 1984,
    parameter int CW      = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sec_tick,
    input  logic          us_tick,
    input  logic          inhibit,
    input  logic [CW-1:0] count,
    output upd_state_e    state,
    output logic          timer_clr,
    output logic          timer_step,
    output logic          finishing,
    output logic          advance,
    output logic          upd_end
);
    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_US - 1);
    localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY_US - 1);

    upd_state_e state_nxt;
    logic       adv_nxt;

    always_comb begin
        state_nxt = state;
        timer_clr = 1'b0;
        adv_nxt   = 1'b0;
        finishing = 1'b0;
        unique case (state)
            ST_IDLE: begin
                timer_clr = 1'b1;
                if (sec_tick && !inhibit) begin
                    state_nxt = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (inhibit) begin
                    state_nxt = ST_IDLE;
                    timer_clr = 1'b1;
                end else if (us_tick && (count == LEAD_LAST)) begin
                    state_nxt = ST_BUSY;
                    timer_clr = 1'b1;
                    adv_nxt   = 1'b1;
                end
            end
            ST_BUSY: begin
                if (us_tick && (count == BUSY_LAST)) begin
                    state_nxt = ST_IDLE;
                    timer_clr = 1'b1;
                    finishing = 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                timer_clr = 1'b1;
            end
        endcase
    end

    assign timer_step = us_tick && (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            advance <= 1'b0;
            upd_end <= 1'b0;
        end else begin
            state   <= state_nxt;
            advance <= adv_nxt;
            upd_end <= finishing;
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      finishing,
    input  clk_time_t now_t,
    input  clk_time_t alm_t,
    output logic      alarm
);
    logic hit;

    assign hit = time_match(now_t, alm_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= 1'b0;
        end else begin
            alarm <= finishing && hit;
        end
    end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_seq_pkg::*;
#(
    parameter int LEAD_US = 244,
    parameter int BUSY_US = 1984
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       us_tick,
    input  logic       inhibit,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hr,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    output logic       uip,
    output logic       bus_hold,
    output logic       advance,
    output logic       upd_end,
    output logic       alarm
);
    localparam int CW = $clog2(max_int(LEAD_US, BUSY_US) + 1);

    upd_state_e    state;
    logic          timer_clr;
    logic          timer_step;
    logic          finishing;
    logic [CW-1:0] count;
    clk_time_t     now_t;
    clk_time_t     alm_t;

    assign now_t = '{hr: cur_hr, min: cur_min, sec: cur_sec};
    assign alm_t = '{hr: alm_hr, min: alm_min, sec: alm_sec};

    rtc_us_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (timer_clr),
        .step  (timer_step),
        .count (count)
    );

    rtc_upd_fsm #(
        .LEAD_US (LEAD_US),
        .BUSY_US (BUSY_US),
        .CW      (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sec_tick   (sec_tick),
        .us_tick    (us_tick),
        .inhibit    (inhibit),
        .count      (count),
        .state      (state),
        .timer_clr  (timer_clr),
        .timer_step (timer_step),
        .finishing  (finishing),
        .advance    (advance),
        .upd_end    (upd_end)
    );

    rtc_alarm_cmp u_alarm (
        .clk       (clk),
        .rst       (rst),
        .finishing (finishing),
        .now_t     (now_t),
        .alm_t     (alm_t),
        .alarm     (alarm)
    );

    assign uip      = (state != ST_IDLE);
    assign bus_hold = (state == ST_BUSY);
endmodule

// File: rtl/rtc_update_seq_chk.sv
module rtc_update_seq_chk #(
    parameter int LEAD_US = 244,
    parameter int BUSY_US = 1984
) (
    input logic clk,
    input logic rst,
    input logic us_tick,
    input logic inhibit,
    input logic uip,
    input logic bus_hold,
    input logic advance,
    input logic upd_end,
    input logic alarm
);
    int unsigned high_us;

    always_ff @(posedge clk) begin
        if (rst || !uip) begin
            high_us <= 0;
        end else if (us_tick) begin
            high_us <= high_us + 1;
        end
    end

    AST_ADV_AFTER_LEAD: assert property (@(posedge clk) disable iff (rst)
        advance |-> (high_us == LEAD_US)); // R3
    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        advance |=> !advance); // R3
    AST_HOLD_INSIDE_UIP: assert property (@(posedge clk) disable iff (rst)
        bus_hold |-> uip); // R3
    AST_UIP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        uip |-> (high_us < LEAD_US + BUSY_US)); // R4
    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        upd_end |-> ($fell(uip) && $past(bus_hold))); // R5
    AST_ALARM_WITH_END: assert property (@(posedge clk) disable iff (rst)
        alarm |-> upd_end); // R6
    AST_INHIBIT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (inhibit && !uip) |=> !uip); // R8
endmodule

bind rtc_update_seq rtc_update_seq_chk #(
    .LEAD_US (LEAD_US),
    .BUSY_US (BUSY_US)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .us_tick  (us_tick),
    .inhibit  (inhibit),
    .uip      (uip),
    .bus_hold (bus_hold),
    .advance  (advance),
    .upd_end  (upd_end),
    .alarm    (alarm)
);

// File: tb/rtc_update_seq_test.sv
module rtc_update_seq_test;
    localparam int L = 244;
    localparam int B = 1984;
    localparam int N = L + B;
    localparam int K_ADV = 0;
    localparam int K_END = 1;
    localparam int K_ALM = 2;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_tick = 1'b0;
    logic us_tick = 1'b1;
    logic inhibit = 1'b0;
    logic slow = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic uip, bus_hold, advance, upd_end, alarm;

    int    cyc = 0;
    int    total = 0;
    int    fails = 0;
    string cur_req = "R1";
    exp_t  sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) us_tick <= slow ? ~us_tick : 1'b1;

    rtc_update_seq #(.LEAD_US(L), .BUSY_US(B)) uut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .us_tick(us_tick),
        .inhibit(inhibit), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hr(cur_hr), .alm_sec(alm_sec), .alm_min(alm_min),
        .alm_hr(alm_hr), .uip(uip), .bus_hold(bus_hold),
        .advance(advance), .upd_end(upd_end), .alarm(alarm)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        sb.push_back('{kind: kind, cyc: at, req: req});
    endtask

    task automatic see_event(input int kind);
        exp_t e;
        total++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL %s: actual event %0d at cycle %0d expected none", cur_req, kind, cyc);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || (e.cyc >= 0 && e.cyc != cyc)) begin
                fails++;
                $display("FAIL %s: actual event %0d at cycle %0d expected event %0d at cycle %0d",
                         e.req, kind, cyc, e.kind, e.cyc);
            end
        end
    endtask

    // Monitor: pops expected events as the design emits them.
    always @(negedge clk) begin
        if (!rst) begin
            if (advance) see_event(K_ADV);
            if (upd_end) see_event(K_END);
            if (alarm)   see_event(K_ALM);
        end
    end

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] as, input logic [7:0] am, input logic [7:0] ah);
        cur_sec = s; cur_min = m; cur_hr = h;
        alm_sec = as; alm_min = am; alm_hr = ah;
    endtask

    // Driver: one full update with the expected events queued.
    task automatic run_update(input bit exp_alm, input string req);
        int t0;
        cur_req = req;
        sec_tick = 1'b1;
        t0 = cyc + 1;
        push(K_ADV, t0 + L, "R3");
        push(K_END, t0 + N, "R5");
        if (exp_alm) push(K_ALM, t0 + N, "R6");
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R2 uip rises", uip, 1);
        wait_to(t0 + L - 1);
        chk("R3 hold before advance", bus_hold, 0);
        wait_to(t0 + L);
        chk("R3 hold at advance", bus_hold, 1);
        wait_to(t0 + N - 1);
        chk("R4 uip last high cycle", uip, 1);
        wait_to(t0 + N);
        chk("R4 uip fallen", uip, 0);
        wait_to(t0 + N + 2);
        chk({req, " queue drained"}, sb.size(), 0);
    endtask

    initial begin
        cyc = 0;
        wait_to(2);
        chk("R1 uip in reset", uip, 0);
        chk("R1 events in reset", int'(advance) + int'(upd_end) + int'(alarm) + int'(bus_hold), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 uip after reset", uip, 0);

        // Normal update, seconds differ -> no alarm (R7)
        set_time(8'h05, 8'h10, 8'h12, 8'h06, 8'h10, 8'h12);
        run_update(1'b0, "R7");

        // Full match -> alarm (R6)
        set_time(8'h30, 8'h45, 8'h09, 8'h30, 8'h45, 8'h09);
        run_update(1'b1, "R6");

        // PM flag mismatch in hours -> no alarm (R6)
        set_time(8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h81);
        run_update(1'b0, "R6");

        // Minutes alone differ -> no alarm (R7)
        set_time(8'h15, 8'h20, 8'h03, 8'h15, 8'h21, 8'h03);
        run_update(1'b0, "R7");

        // Tick while inhibited is dropped (R8)
        cur_req = "R8";
        inhibit = 1'b1;
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R8 uip stays low", uip, 0);
        repeat (L + 20) @(negedge clk);
        chk("R8 still idle", uip, 0);
        chk("R8 no events", sb.size(), 0);
        inhibit = 1'b0;
        @(negedge clk);
        set_time(8'h01, 8'h02, 8'h03, 8'h01, 8'h02, 8'h03);
        run_update(1'b1, "R8");

        // Inhibit during lead aborts (R9)
        begin
            int t0;
            cur_req = "R9";
            sec_tick = 1'b1;
            t0 = cyc + 1;
            @(negedge clk);
            sec_tick = 1'b0;
            wait_to(t0 + 10);
            inhibit = 1'b1;
            @(negedge clk);
            chk("R9 uip falls on abort", uip, 0);
            repeat (N + 10) @(negedge clk);
            chk("R9 stays idle", uip, 0);
            inhibit = 1'b0;
            @(negedge clk);
        end

        // Inhibit during busy window does not abort (R10)
        begin
            int t0;
            cur_req = "R10";
            set_time(8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00);
            sec_tick = 1'b1;
            t0 = cyc + 1;
            push(K_ADV, t0 + L, "R10");
            push(K_END, t0 + N, "R10");
            @(negedge clk);
            sec_tick = 1'b0;
            wait_to(t0 + L + 5);
            inhibit = 1'b1;
            wait_to(t0 + N - 1);
            chk("R10 uip still high", uip, 1);
            wait_to(t0 + N + 2);
            chk("R10 uip low", uip, 0);
            chk("R10 end delivered", sb.size(), 0);
            inhibit = 1'b0;
            @(negedge clk);
        end

        // Second tick mid-update is ignored (R12)
        begin
            int t0;
            cur_req = "R12";
            sec_tick = 1'b1;
            t0 = cyc + 1;
            push(K_ADV, t0 + L, "R12");
            push(K_END, t0 + N, "R12");
            @(negedge clk);
            sec_tick = 1'b0;
            wait_to(t0 + 100);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
            wait_to(t0 + L + 50);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
            wait_to(t0 + N - 1);
            chk("R12 uip high to end", uip, 1);
            wait_to(t0 + N);
            chk("R12 uip falls on time", uip, 0);
            repeat (L + 10) @(negedge clk);
            chk("R12 no restart", uip, 0);
            chk("R12 single set of events", sb.size(), 0);
        end

        // Half-rate timebase stretches timing (R11)
        begin
            int hi;
            int ok;
            cur_req = "R11";
            slow = 1'b1;
            repeat (4) @(negedge clk);
            push(K_ADV, -1, "R11");
            push(K_END, -1, "R11");
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
            hi = 0;
            while (uip && hi < 3 * N) begin
                hi++;
                @(negedge clk);
            end
            ok = (hi == 2 * N - 1 || hi == 2 * N) ? 1 : 0;
            if (ok == 0) $display("R11 measured %0d cycles", hi);
            chk("R11 stretched uip window", ok, 1);
            repeat (3) @(negedge clk);
            chk("R11 events delivered", sb.size(), 0);
            slow = 1'b0;
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        total++;
        fails++;
        $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule